// File: doc/BRIEF.md
# Dual-Strobe Decade Up/Down Counter

This block holds one decimal digit (0 to 9) in a four-bit register and steps it by one on the rising edge of either of two count strobes: one strobe counts up, the other counts down. Both strobes are asynchronous to the system clock. Each passes through a two-flop synchronizer, and a registered copy of the synchronized level is used to find its rising edge. A rising edge is counted only while the other strobe has been HIGH for at least the current and the previous sampled cycle. As a result, simultaneous or overlapping strobes never produce a count.

An asynchronous active-HIGH clear forces the digit to zero. An active-LOW load copies the four data inputs into the digit. Both take priority over the strobes. Two active-LOW terminal-count outputs repeat the LOW phase of the matching strobe while the digit sits at its end value (9 going up, 0 going down). A following stage can use them directly as its own count strobes.

Top module: `bcd_updown_counter`

## Requirements
- R1: A rising edge on `upStrobe` (with `downStrobe` HIGH) raises the digit by one; 9 wraps to 0.
- R2: A rising edge on `downStrobe` (with `upStrobe` HIGH) lowers the digit by one; 0 wraps to 9.
- R3: Exactly one step is taken per rising edge. Falling edges and steady levels leave the digit unchanged.
- R4: A rising edge of one strobe is ignored while the other strobe is LOW. Such an edge leaves the digit unchanged.
- R5: `clearIn` HIGH forces `count` to 0 at once, without waiting for a clock edge. It overrides load and both strobes.
- R6: While `loadN` is LOW, each clock edge copies `dataIn` into `count`, and strobe edges are ignored.
- R7: A strobe held LOW through a clear or a load gives exactly one step on its first rising edge after release.
- R8: `upTcN` is LOW exactly when `count` is 9 and the synchronized `upStrobe` is LOW.
- R9: `downTcN` is LOW exactly when `count` is 0 and the synchronized `downStrobe` is LOW.
- R10: A loaded value of 10 to 14 counts up to the next value, and 15 counts up to 0. A down count from 10 to 15 subtracts one.
- R11: `count` changes on the third rising clock edge after a counted strobe rises: two synchronizer flops, then the count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the strobes |
| clearIn | input | 1 | Asynchronous clear, active HIGH |
| loadN | input | 1 | Parallel load, active LOW |
| dataIn | input | 4 | Value loaded while `loadN` is LOW |
| upStrobe | input | 1 | Up count strobe, counts on rising edge |
| downStrobe | input | 1 | Down count strobe, counts on rising edge |
| count | output | 4 | Current digit |
| upTcN | output | 1 | Up terminal count, active LOW |
| downTcN | output | 1 | Down terminal count, active LOW |

## Verification
The assertions check the following on every cycle:
- clear holds the digit at zero;
- a load produces the data value;
- a digit inside 0 to 9 never leaves that range without a load;
- between loads the digit moves by at most one legal step;
- each terminal-count output is LOW only at its end value.

Only the directed scenarios can show the following:
- whether a particular edge was counted or correctly ignored;
- the three-edge latency;
- the single count after a strobe held LOW through clear or load;
- the wrap behaviour of out-of-range loaded values.

// File: rtl/bcd_counter_pkg.sv
package bcd_counter_pkg;
  localparam int DIGIT_W    = 4;
  localparam int DIGIT_MAX  = 9;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } ctrlStrobes_t;
endpackage

// File: rtl/bcd_strobe_ctrl.sv
module bcd_strobe_ctrl
  import bcd_counter_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         clearIn,
  input  logic         loadN,
  input  logic         upStrobe,
  input  logic         downStrobe,
  output ctrlStrobes_t strobes,
  output logic         upLevel,
  output logic         downLevel
);
  localparam logic [SYNC_STAGES-1:0] SYNC_IDLE = '1;

  logic [SYNC_STAGES-1:0] upSh, downSh;
  logic upPrev, downPrev;

  // Synchronizer chains reset HIGH so a strobe held LOW through clear yields one edge later.
  always_ff @(posedge clk or posedge clearIn) begin
    if (clearIn) begin
      upSh     <= SYNC_IDLE;
      downSh   <= SYNC_IDLE;
      upPrev   <= 1'b1;
      downPrev <= 1'b1;
    end else begin
      upSh     <= {upSh[SYNC_STAGES-2:0], upStrobe};
      downSh   <= {downSh[SYNC_STAGES-2:0], downStrobe};
      upPrev   <= upSh[SYNC_STAGES-1];
      downPrev <= downSh[SYNC_STAGES-1];
    end
  end

  assign upLevel   = upSh[SYNC_STAGES-1];
  assign downLevel = downSh[SYNC_STAGES-1];

  always_comb begin
    strobes.load = ~loadN;
    // The idle strobe must have been HIGH now and one sample earlier.
    strobes.inc  = upLevel & ~upPrev & downLevel & downPrev;
    strobes.dec  = downLevel & ~downPrev & upLevel & upPrev;
  end
endmodule

// File: rtl/bcd_count_datapath.sv
module bcd_count_datapath
  import bcd_counter_pkg::*;
#(
  parameter int W   = DIGIT_W,
  parameter int MAX = DIGIT_MAX
) (
  input  logic         clk,
  input  logic         clearIn,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] dataIn,
  input  logic         upLevel,
  input  logic         downLevel,
  output logic [W-1:0] count,
  output logic         upTcN,
  output logic         downTcN
);
  localparam logic [W-1:0] TOP_VAL  = W'(MAX);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] upNext, downNext;

  always_comb begin
    if (count == TOP_VAL || count == ALL_ONES) upNext = '0;
    else                                       upNext = count + 1'b1;
    if (count == '0) downNext = TOP_VAL;
    else             downNext = count - 1'b1;
  end

  always_ff @(posedge clk or posedge clearIn) begin
    if (clearIn)          count <= '0;
    else if (strobes.load) count <= dataIn;
    else if (strobes.inc)  count <= upNext;
    else if (strobes.dec)  count <= downNext;
  end

  assign upTcN   = ~((count == TOP_VAL) & ~upLevel);
  assign downTcN = ~((count == '0) & ~downLevel);
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_counter_pkg::*;
(
  input  logic               clk,
  input  logic               clearIn,
  input  logic               loadN,
  input  logic [DIGIT_W-1:0] dataIn,
  input  logic               upStrobe,
  input  logic               downStrobe,
  output logic [DIGIT_W-1:0] count,
  output logic               upTcN,
  output logic               downTcN
);
  ctrlStrobes_t strobes;
  logic upLevel, downLevel;

  bcd_strobe_ctrl #(.SYNC_STAGES(SYNC_DEPTH)) u_ctrl (
    .clk(clk), .clearIn(clearIn), .loadN(loadN),
    .upStrobe(upStrobe), .downStrobe(downStrobe),
    .strobes(strobes), .upLevel(upLevel), .downLevel(downLevel)
  );

  bcd_count_datapath #(.W(DIGIT_W), .MAX(DIGIT_MAX)) u_dp (
    .clk(clk), .clearIn(clearIn), .strobes(strobes), .dataIn(dataIn),
    .upLevel(upLevel), .downLevel(downLevel),
    .count(count), .upTcN(upTcN), .downTcN(downTcN)
  );
endmodule

// File: rtl/bcd_counter_chk.sv
module bcd_counter_chk
  import bcd_counter_pkg::*;
(
  input logic               clk,
  input logic               clearIn,
  input logic               loadN,
  input logic [DIGIT_W-1:0] dataIn,
  input logic [DIGIT_W-1:0] count,
  input logic               upTcN,
  input logic               downTcN
);
  function automatic logic [DIGIT_W-1:0] stepUp(logic [DIGIT_W-1:0] v);
    return (v == DIGIT_W'(DIGIT_MAX) || v == '1) ? '0 : v + 1'b1;
  endfunction
  function automatic logic [DIGIT_W-1:0] stepDown(logic [DIGIT_W-1:0] v);
    return (v == '0) ? DIGIT_W'(DIGIT_MAX) : v - 1'b1;
  endfunction

  // R5
  clear_zero_chk: assert property (@(posedge clk) clearIn |-> count == '0);

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (clearIn)
    !loadN |=> count == $past(dataIn));

  // R1
  bcd_range_chk: assert property (@(posedge clk) disable iff (clearIn)
    (loadN && count <= DIGIT_W'(DIGIT_MAX)) |=> count <= DIGIT_W'(DIGIT_MAX));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (clearIn)
    loadN |=> (count == $past(count) || count == stepUp($past(count))
               || count == stepDown($past(count))));

  // R8
  up_tc_chk: assert property (@(posedge clk) disable iff (clearIn)
    !upTcN |-> count == DIGIT_W'(DIGIT_MAX));

  // R9
  down_tc_chk: assert property (@(posedge clk) disable iff (clearIn)
    !downTcN |-> count == '0);
endmodule

bind bcd_updown_counter bcd_counter_chk chk0 (
  .clk(clk), .clearIn(clearIn), .loadN(loadN), .dataIn(dataIn),
  .count(count), .upTcN(upTcN), .downTcN(downTcN)
);

// File: tb/sim_bcd_updown_counter.sv
`timescale 1ns/1ps
module sim_bcd_updown_counter;
  logic clk = 1'b0;
  logic clearIn = 1'b1, loadN = 1'b1, upStrobe = 1'b1, downStrobe = 1'b1;
  logic [3:0] dataIn = '0;
  logic [3:0] count;
  logic upTcN, downTcN;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  bcd_updown_counter u0 (
    .clk(clk), .clearIn(clearIn), .loadN(loadN), .dataIn(dataIn),
    .upStrobe(upStrobe), .downStrobe(downStrobe),
    .count(count), .upTcN(upTcN), .downTcN(downTcN)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseUp();
    upStrobe = 1'b0; waitCyc(4); upStrobe = 1'b1; waitCyc(4);
  endtask
  task automatic pulseDown();
    downStrobe = 1'b0; waitCyc(4); downStrobe = 1'b1; waitCyc(4);
  endtask
  task automatic loadVal(logic [3:0] v);
    dataIn = v; loadN = 1'b0; waitCyc(1); loadN = 1'b1; waitCyc(1);
  endtask

  task automatic testReset();
    check("R5 reset count", count, 0);
    check("R9 reset downTcN", downTcN, 1);
    check("R8 reset upTcN", upTcN, 1);
    clearIn = 1'b0; waitCyc(3);
  endtask

  task automatic testUpWrap();
    for (int i = 1; i <= 10; i++) begin
      pulseUp();
      check("R1 up count", count, i % 10);
    end
  endtask

  task automatic testDownWrap();
    pulseDown();
    check("R2 down wrap 0->9", count, 9);
    pulseDown();
    check("R2 down 9->8", count, 8);
  endtask

  task automatic testLatency();
    upStrobe = 1'b0; waitCyc(4);
    check("R3 falling edge no step", count, 8);
    upStrobe = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R11 no change after two edges", count, 8);
    @(posedge clk); #1;
    check("R11 change on third edge", count, 9);
    waitCyc(4);
    check("R3 steady level no extra step", count, 9);
  endtask

  task automatic testTerminal();
    upStrobe = 1'b0; waitCyc(4);
    check("R8 upTcN low at 9 with strobe low", upTcN, 0);
    upStrobe = 1'b1; waitCyc(4);
    check("R8 upTcN high with strobe high", upTcN, 1);
    check("R1 wrap to 0", count, 0);
    downStrobe = 1'b0; waitCyc(4);
    check("R9 downTcN low at 0", downTcN, 0);
    check("R8 upTcN high at 0", upTcN, 1);
    downStrobe = 1'b1; waitCyc(4);
    check("R9 downTcN high at 9", downTcN, 1);
    check("R2 count 9", count, 9);
  endtask

  task automatic testInterlock();
    loadVal(4'd5);
    downStrobe = 1'b0; waitCyc(4);
    pulseUp();
    check("R4 up ignored while down low", count, 5);
    upStrobe = 1'b0; waitCyc(4);
    downStrobe = 1'b1; waitCyc(4);
    check("R4 down ignored while up low", count, 5);
    upStrobe = 1'b1; waitCyc(4);
    check("R1 up counts after down released", count, 6);
    upStrobe = 1'b0; downStrobe = 1'b0; waitCyc(4);
    upStrobe = 1'b1; downStrobe = 1'b1; waitCyc(4);
    check("R4 simultaneous edges ignored", count, 6);
  endtask

  task automatic testLoadClear();
    dataIn = 4'd3; loadN = 1'b0; upStrobe = 1'b0; waitCyc(2);
    upStrobe = 1'b1; waitCyc(4);
    check("R6 load holds, edge ignored", count, 3);
    upStrobe = 1'b0; waitCyc(2);
    loadN = 1'b1; waitCyc(4);
    check("R7 no step at load release", count, 3);
    upStrobe = 1'b1; waitCyc(4);
    check("R7 one step after load", count, 4);
    downStrobe = 1'b0; #1 clearIn = 1'b1; #1;
    check("R5 async clear", count, 0);
    dataIn = 4'd7; loadN = 1'b0; waitCyc(2);
    check("R5 clear overrides load", count, 0);
    loadN = 1'b1; clearIn = 1'b0; waitCyc(4);
    downStrobe = 1'b1; waitCyc(4);
    check("R7 one step after clear", count, 9);
  endtask

  task automatic testIllegal();
    loadVal(4'd12);
    check("R6 load 12", count, 12);
    pulseUp();
    check("R10 12 up to 13", count, 13);
    pulseUp(); pulseUp();
    check("R10 15 reached", count, 15);
    pulseUp();
    check("R10 15 up to 0", count, 0);
    loadVal(4'd11);
    pulseDown();
    check("R10 11 down to 10", count, 10);
  endtask

  initial begin
    fork
      begin
        waitCyc(3);
        testReset();
        testUpWrap();
        testDownWrap();
        testLatency();
        testTerminal();
        testInterlock();
        testLoadClear();
        testIllegal();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule